// File: doc/BRIEF.md
# Lockable Translation Cache with Replacement Pointer

This block is a small fully associative translation cache for a device address space. Each slot holds a tag word and a data word. The tag word carries a virtual page number, a valid bit and a page-size code. The data word carries a physical page number and attribute bits. Software stages a tag word and a data word on input ports. A load strobe then writes them into the slot that a replacement pointer selects.

A lock register holds two fields. The floor field marks how many low slots are pinned. The pointer field names the slot that the next load writes. Pinned slots are never chosen for replacement and survive a global invalidation. Only an explicit invalidation by address removes them.

A lookup port takes a device virtual address. One cycle later it returns hit, the translated physical address and the attributes. The slot count is a parameter that must be 8 or 32. Any other value stops elaboration with an error.

Top module: `ltlb_top`

## Requirements
- R1: The lock register reads back the floor field at bits [14:10] and the pointer field at bits [8:4]; all other bits read zero. A write through `lock_wr` takes effect on the next clock. Both fields are zero after reset.
- R2: Staged tag word layout: virtual page number at [31:12], valid at [2], size code at [1:0]. The size codes are 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB and 3 = 16 MiB. Staged data word layout: physical page number at [31:12], attributes at [7:0].
- R3: An accepted load writes the staged tag and data words into the slot named by the pointer field.
- R4: After an accepted load the pointer field increments. When the increment would reach the slot count, the pointer returns to the floor field instead.
- R5: A load is refused when the floor or the pointer is at or above the slot count. A refused load writes no slot and leaves the lock register unchanged. `load_err` is high for the one cycle after the refused strobe.
- R6: A slot matches an address when it is valid and start <= address < start + page bytes. Here start is the tag's virtual page address aligned down to the slot's page size.
- R7: A lookup presented with `lk_valid` produces `res_valid` one cycle later. On a hit, `res_pa` = (physical page AND size mask) OR (address AND NOT size mask), and `res_attr` carries the slot's attributes.
- R8: When several slots match, the lowest-numbered slot supplies the result.
- R9: `inval_one` invalidates every slot that covers `inval_va`, pinned slots included.
- R10: `inval_all` invalidates every slot at or above the floor field, keeps the slots below it, and sets both lock fields to zero.
- R11: Priority in a single cycle: `inval_all` first, then `lock_wr`, then a load. A load that loses to either is dropped without writing a slot and without raising `load_err`.
- R12: A lookup in the same cycle as a load or an invalidation sees the slot contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_wr | input | 1 | Write strobe for the lock register |
| lock_wdata | input | 32 | Lock register write value |
| lock_rdata | output | 32 | Lock register read value |
| stage_tag | input | 32 | Staged tag word |
| stage_data | input | 32 | Staged data word |
| load_stb | input | 1 | Load the staged words into the pointed slot |
| load_err | output | 1 | One-cycle pulse after a refused load |
| inval_va | input | 32 | Address for invalidation by address |
| inval_one | input | 1 | Invalidate slots covering `inval_va` |
| inval_all | input | 1 | Invalidate all unpinned slots, clear lock fields |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup hit |
| res_pa | output | 32 | Translated physical address |
| res_attr | output | 8 | Attributes of the hitting slot |

## Verification
The lookup path and the slot-update path can act in the same cycle. The bench issues a lookup in the very cycle of a load into the slot the lookup targets, of an invalidation by address, and of a global invalidation. It expects the old contents for that lookup and the new contents for the next one. The register write and the load also share a cycle with the global invalidation. The lock readback and later lookups show which of them won.

// File: rtl/ltlb_pkg.sv
package ltlb_pkg;

    localparam int ADDR_W    = 32;
    localparam int PAGE_SH   = 12;
    localparam int VPN_W     = ADDR_W - PAGE_SH;
    localparam int ATTR_W    = 8;
    localparam int LOCK_FW   = 5;
    localparam int FLOOR_LSB = 10;
    localparam int PTR_LSB   = 4;
    localparam int TAG_SPARE = ADDR_W - VPN_W - 3;
    localparam int DAT_SPARE = ADDR_W - VPN_W - ATTR_W;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic [VPN_W-1:0]     vpn;
        logic [TAG_SPARE-1:0] spare;
        logic                 valid;
        pgsz_e                size;
    } tag_t;

    typedef struct packed {
        logic [VPN_W-1:0]     ppn;
        logic [DAT_SPARE-1:0] spare;
        logic [ATTR_W-1:0]    attr;
    } data_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] pa;
        logic [ATTR_W-1:0] attr;
    } xlat_t;

    // each size code step multiplies the page by 16
    function automatic logic [ADDR_W-1:0] page_mask(pgsz_e s);
        logic [ADDR_W-1:0] ones;
        ones = '1;
        return ones << (PAGE_SH + 4 * int'(s));
    endfunction

    function automatic logic covers(tag_t t, logic [ADDR_W-1:0] va);
        logic [ADDR_W-1:0] m;
        m = page_mask(t.size);
        return t.valid && ((va & m) == ({t.vpn, {PAGE_SH{1'b0}}} & m));
    endfunction

endpackage

// File: rtl/ltlb_lock.sv
module ltlb_lock
    import ltlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_wdata,
    input  logic               load_stb,
    input  logic               flush_all,
    output logic [LOCK_FW-1:0] floor_q,
    output logic [LOCK_FW-1:0] ptr_q,
    output logic               load_go,
    output logic               load_err
);
    localparam logic [LOCK_FW:0] CNT = (LOCK_FW+1)'(ENTRIES);
    localparam logic [LOCK_FW:0] ONE = (LOCK_FW+1)'(1);

    logic             full;
    logic             busy;
    logic [LOCK_FW:0] nxt;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata[ADDR_W-1:FLOOR_LSB+LOCK_FW],
                            reg_wdata[FLOOR_LSB-1:PTR_LSB+LOCK_FW],
                            reg_wdata[PTR_LSB-1:0]};

    assign full    = ({1'b0, floor_q} >= CNT) || ({1'b0, ptr_q} >= CNT);
    assign busy    = flush_all || reg_wr;
    assign load_go = load_stb && !busy && !full;
    assign nxt     = {1'b0, ptr_q} + ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            floor_q  <= '0;
            ptr_q    <= '0;
            load_err <= 1'b0;
        end else begin
            load_err <= load_stb && !busy && full;
            if (flush_all) begin
                floor_q <= '0;
                ptr_q   <= '0;
            end else if (reg_wr) begin
                floor_q <= reg_wdata[FLOOR_LSB +: LOCK_FW];
                ptr_q   <= reg_wdata[PTR_LSB +: LOCK_FW];
            end else if (load_go) begin
                ptr_q <= (nxt >= CNT) ? floor_q : nxt[LOCK_FW-1:0];
            end
        end
    end

    AST_FULL_ERR: assert property (@(posedge clk) disable iff (rst)
        (load_stb && !busy && ({1'b0, floor_q} >= CNT)) |=> load_err) // R5
        else $error("refused load did not raise load_err");

    AST_ERR_SRC: assert property (@(posedge clk) disable iff (rst)
        load_err |-> $past(load_stb)) // R5
        else $error("load_err without a load strobe");

    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (load_go && (nxt >= CNT)) |=> (ptr_q == $past(floor_q))) // R4
        else $error("pointer did not return to floor");

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        (load_go && (nxt < CNT)) |=> (ptr_q == LOCK_FW'($past(ptr_q) + 1'b1))) // R4
        else $error("pointer did not advance");

    AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (floor_q == '0 && ptr_q == '0)) // R10
        else $error("global invalidation left lock fields set");

    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (load_stb && busy) |=> !load_err) // R11
        else $error("dropped load raised an error");

endmodule

// File: rtl/ltlb_slot.sv
module ltlb_slot
    import ltlb_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LOCK_FW-1:0] floor_q,
    input  logic               flush_all,
    input  logic               wr_en,
    input  tag_t               wr_tag,
    input  data_t              wr_data,
    input  logic               flush_one,
    input  logic [ADDR_W-1:0]  flush_va,
    input  logic [ADDR_W-1:0]  lk_va,
    output xlat_t              cand
);
    localparam logic [LOCK_FW:0] MY_IDX = (LOCK_FW+1)'(IDX);

    tag_t              tag_q;
    data_t             data_q;
    logic              pinned;
    logic              fl_hit;
    logic [ADDR_W-1:0] m;
    logic              unused_spare;

    assign unused_spare = ^{tag_q.spare, data_q.spare};

    assign pinned    = MY_IDX < {1'b0, floor_q};
    assign fl_hit    = covers(tag_q, flush_va);
    assign m         = page_mask(tag_q.size);
    assign cand.hit  = covers(tag_q, lk_va);
    assign cand.pa   = ({data_q.ppn, {PAGE_SH{1'b0}}} & m) | (lk_va & ~m);
    assign cand.attr = data_q.attr;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            data_q <= '0;
        end else if (flush_all && !pinned) begin
            tag_q.valid <= 1'b0;
        end else if (wr_en) begin
            tag_q  <= wr_tag;
            data_q <= wr_data;
        end else if (flush_one && fl_hit) begin
            tag_q.valid <= 1'b0;
        end
    end

    AST_LOAD_WR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush_all) |=> (tag_q == $past(wr_tag))) // R3
        else $error("slot not written by load");

    AST_PIN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (flush_all && pinned && tag_q.valid && !flush_one) |=> tag_q.valid) // R10
        else $error("pinned slot lost by global invalidation");

    AST_INV_ONE: assert property (@(posedge clk) disable iff (rst)
        (flush_one && fl_hit && !wr_en) |=> !tag_q.valid) // R9
        else $error("covering slot survived invalidation by address");

endmodule

// File: rtl/ltlb_pick.sv
module ltlb_pick
    import ltlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [ADDR_W-1:0]   lk_va,
    input  xlat_t [ENTRIES-1:0] cands,
    output logic                res_valid,
    output xlat_t               res
);
    xlat_t win;

    // walk from the top so the lowest matching index is the last to assign
    always_comb begin
        win = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cands[i].hit) win = cands[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= lk_valid;
            res       <= lk_valid ? win : '0;
        end
    end

    AST_RES_LAT: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid) // R7
        else $error("lookup result missing");

    AST_MISS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res.hit) // R7
        else $error("hit reported without a lookup");

    AST_PA_OFS: assert property (@(posedge clk) disable iff (rst)
        res.hit |-> (res.pa[PAGE_SH-1:0] == $past(lk_va[PAGE_SH-1:0]))) // R7
        else $error("page offset not carried through");

endmodule

// File: rtl/ltlb_top.sv
module ltlb_top
    import ltlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_wr,
    input  logic [31:0]       lock_wdata,
    output logic [31:0]       lock_rdata,
    input  logic [31:0]       stage_tag,
    input  logic [31:0]       stage_data,
    input  logic              load_stb,
    output logic              load_err,
    input  logic [31:0]       inval_va,
    input  logic              inval_one,
    input  logic              inval_all,
    input  logic              lk_valid,
    input  logic [31:0]       lk_va,
    output logic              res_valid,
    output logic              res_hit,
    output logic [31:0]       res_pa,
    output logic [7:0]        res_attr
);
    localparam int IDX_W = $clog2(ENTRIES);

    if (ENTRIES != 8 && ENTRIES != 32) begin : g_bad_cfg
        initial $error("ltlb_top: ENTRIES must be 8 or 32");
    end

    logic [LOCK_FW-1:0]  floor_q;
    logic [LOCK_FW-1:0]  ptr_q;
    logic                load_go;
    tag_t                st_tag;
    data_t               st_data;
    xlat_t [ENTRIES-1:0] cands;
    xlat_t               res;

    assign st_tag  = tag_t'(stage_tag);
    assign st_data = data_t'(stage_data);

    always_comb begin
        lock_rdata = '0;
        lock_rdata[FLOOR_LSB +: LOCK_FW] = floor_q;
        lock_rdata[PTR_LSB +: LOCK_FW]   = ptr_q;
    end

    ltlb_lock #(.ENTRIES(ENTRIES)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (lock_wr),
        .reg_wdata (lock_wdata),
        .load_stb  (load_stb),
        .flush_all (inval_all),
        .floor_q   (floor_q),
        .ptr_q     (ptr_q),
        .load_go   (load_go),
        .load_err  (load_err)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic wr_en;
        assign wr_en = load_go && (ptr_q[IDX_W-1:0] == IDX_W'(i));

        ltlb_slot #(.IDX(i)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .floor_q   (floor_q),
            .flush_all (inval_all),
            .wr_en     (wr_en),
            .wr_tag    (st_tag),
            .wr_data   (st_data),
            .flush_one (inval_one),
            .flush_va  (inval_va),
            .lk_va     (lk_va),
            .cand      (cands[i])
        );
    end

    ltlb_pick #(.ENTRIES(ENTRIES)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .lk_valid  (lk_valid),
        .lk_va     (lk_va),
        .cands     (cands),
        .res_valid (res_valid),
        .res       (res)
    );

    assign res_hit  = res.hit;
    assign res_pa   = res.pa;
    assign res_attr = res.attr;

endmodule

// File: tb/ltlb_top_bench.sv
module ltlb_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock_wr = 1'b0;
    logic [31:0] lock_wdata = '0;
    logic [31:0] lock_rdata;
    logic [31:0] stage_tag = '0;
    logic [31:0] stage_data = '0;
    logic        load_stb = 1'b0;
    logic        load_err;
    logic [31:0] inval_va = '0;
    logic        inval_one = 1'b0;
    logic        inval_all = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        res_valid;
    logic        res_hit;
    logic [31:0] res_pa;
    logic [7:0]  res_attr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic        hit;
        logic [31:0] pa;
        logic [7:0]  attr;
        string       req;
    } exp_t;

    exp_t expq[$];
    exp_t mon_e;

    always #4 clk = ~clk;

    ltlb_top #(.ENTRIES(8)) u_ltlb_top (
        .clk(clk), .rst(rst),
        .lock_wr(lock_wr), .lock_wdata(lock_wdata), .lock_rdata(lock_rdata),
        .stage_tag(stage_tag), .stage_data(stage_data),
        .load_stb(load_stb), .load_err(load_err),
        .inval_va(inval_va), .inval_one(inval_one), .inval_all(inval_all),
        .lk_valid(lk_valid), .lk_va(lk_va),
        .res_valid(res_valid), .res_hit(res_hit), .res_pa(res_pa), .res_attr(res_attr)
    );

    // R2: tag = vpn[31:12], valid[2], size[1:0]; data = ppn[31:12], attr[7:0]
    function automatic logic [31:0] mk_tag(logic [31:0] va, logic [1:0] sz);
        return {va[31:12], 9'b0, 1'b1, sz};
    endfunction

    function automatic logic [31:0] mk_data(logic [19:0] ppn, logic [7:0] attr);
        return {ppn, 4'b0, attr};
    endfunction

    // R1: floor at [14:10], pointer at [8:4]
    function automatic logic [31:0] lk_word(int fl, int pt);
        return (32'(fl) << 10) | (32'(pt) << 4);
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic look(logic [31:0] va, logic hit, logic [31:0] pa, logic [7:0] attr, string req);
        exp_t e;
        e.hit = hit; e.pa = pa; e.attr = attr; e.req = req;
        expq.push_back(e);
        lk_va = va;
        lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic load(logic [31:0] tag, logic [31:0] data);
        stage_tag = tag;
        stage_data = data;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic wr_lock(logic [31:0] w);
        lock_wdata = w;
        lock_wr = 1'b1;
        @(negedge clk);
        lock_wr = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            checks++;
            if (expq.size() == 0) begin
                failures++;
                $display("FAIL R7: result with no pending lookup hit=%0b pa=%h", res_hit, res_pa);
            end else begin
                mon_e = expq.pop_front();
                if (res_hit !== mon_e.hit ||
                    (mon_e.hit && (res_pa !== mon_e.pa || res_attr !== mon_e.attr))) begin
                    failures++;
                    $display("FAIL %s: actual hit=%0b pa=%h attr=%h expected hit=%0b pa=%h attr=%h",
                             mon_e.req, res_hit, res_pa, res_attr, mon_e.hit, mon_e.pa, mon_e.attr);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check32("R1 reset lock", lock_rdata, 32'h0);
        check32("R1 reset res_valid", {31'b0, res_valid}, 32'h0);
        check32("R5 reset load_err", {31'b0, load_err}, 32'h0);

        // slots 0 and 1, later pinned
        load(mk_tag(32'h0001_0000, 2'd0), mk_data(20'hAAAAA, 8'h11));
        load(mk_tag(32'h0030_0000, 2'd2), mk_data(20'h12300, 8'h22));
        check32("R4 pointer after two loads", lock_rdata, lk_word(0, 2));
        wr_lock(lk_word(2, 2));
        check32("R1 lock readback", lock_rdata, lk_word(2, 2));

        load(mk_tag(32'h0040_0000, 2'd1), mk_data(20'h55550, 8'h33));
        load(mk_tag(32'h0500_0000, 2'd3), mk_data(20'h07000, 8'h44));
        load(mk_tag(32'h0030_0000, 2'd0), mk_data(20'hBBBBB, 8'h55));

        look(32'h0001_0ABC, 1'b1, 32'hAAAA_AABC, 8'h11, "R7 4K translate");
        look(32'h0001_1000, 1'b0, 32'h0, 8'h0, "R6 4K end boundary");
        look(32'h0000_FFFF, 1'b0, 32'h0, 8'h0, "R6 below start");
        look(32'h003F_FFFF, 1'b1, 32'h123F_FFFF, 8'h22, "R6 1M last byte");
        look(32'h0030_0123, 1'b1, 32'h1230_0123, 8'h22, "R8 lowest index wins");
        look(32'h0040_ABCD, 1'b1, 32'h5555_ABCD, 8'h33, "R7 64K translate");
        look(32'h05FF_FFF0, 1'b1, 32'h07FF_FFF0, 8'h44, "R7 16M translate");

        load(mk_tag(32'h1000_0000, 2'd0), mk_data(20'h20000, 8'h01));
        load(mk_tag(32'h1000_1000, 2'd0), mk_data(20'h20001, 8'h02));
        load(mk_tag(32'h1000_2000, 2'd0), mk_data(20'h20002, 8'h03));
        check32("R4 pointer wraps to floor", lock_rdata, lk_word(2, 2));

        load(mk_tag(32'h0080_0000, 2'd0), mk_data(20'h66666, 8'h66));
        look(32'h0040_ABCD, 1'b0, 32'h0, 8'h0, "R3 replaced slot gone");
        look(32'h0080_0010, 1'b1, 32'h6666_6010, 8'h66, "R3 new slot hit");
        look(32'h0001_0ABC, 1'b1, 32'hAAAA_AABC, 8'h11, "R4 pinned slot kept");

        // invalidation by address with a lookup in the same cycle
        inval_va = 32'h0030_0500;
        inval_one = 1'b1;
        look(32'h0030_0500, 1'b1, 32'h1230_0500, 8'h22, "R12 lookup sees old slot");
        inval_one = 1'b0;
        look(32'h0030_0500, 1'b0, 32'h0, 8'h0, "R9 covering slots invalidated");
        look(32'h003F_FFFF, 1'b0, 32'h0, 8'h0, "R9 pinned 1M slot invalidated");

        // load with a lookup in the same cycle
        stage_tag = mk_tag(32'h0090_0000, 2'd0);
        stage_data = mk_data(20'h77777, 8'h77);
        load_stb = 1'b1;
        look(32'h0090_0000, 1'b0, 32'h0, 8'h0, "R12 lookup before load lands");
        load_stb = 1'b0;
        look(32'h0090_0004, 1'b1, 32'h7777_7004, 8'h77, "R3 load visible next cycle");
        look(32'h05FF_FFF0, 1'b0, 32'h0, 8'h0, "R3 16M slot replaced");

        // refused load
        wr_lock(lk_word(8, 4));
        load(mk_tag(32'h00A0_0000, 2'd0), mk_data(20'h88888, 8'h88));
        check32("R5 load_err pulse", {31'b0, load_err}, 32'h1);
        check32("R5 lock unchanged", lock_rdata, lk_word(8, 4));
        look(32'h00A0_0000, 1'b0, 32'h0, 8'h0, "R5 refused load wrote nothing");
        check32("R5 load_err one cycle", {31'b0, load_err}, 32'h0);

        // global invalidation with a lookup in the same cycle
        wr_lock(lk_word(2, 4));
        inval_all = 1'b1;
        look(32'h0080_0010, 1'b1, 32'h6666_6010, 8'h66, "R12 lookup before global invalidate");
        inval_all = 1'b0;
        check32("R10 lock cleared", lock_rdata, 32'h0);
        look(32'h0001_0ABC, 1'b1, 32'hAAAA_AABC, 8'h11, "R10 pinned slot survives");
        look(32'h0080_0010, 1'b0, 32'h0, 8'h0, "R10 unpinned slot cleared");
        look(32'h0090_0004, 1'b0, 32'h0, 8'h0, "R10 unpinned slot cleared");

        // priorities
        lock_wdata = lk_word(3, 3);
        lock_wr = 1'b1;
        inval_all = 1'b1;
        @(negedge clk);
        lock_wr = 1'b0;
        inval_all = 1'b0;
        check32("R11 global invalidate beats write", lock_rdata, 32'h0);
        wr_lock(lk_word(3, 3));
        check32("R1 lock readback", lock_rdata, lk_word(3, 3));
        lock_wdata = lk_word(0, 5);
        lock_wr = 1'b1;
        load(mk_tag(32'h00B0_0000, 2'd0), mk_data(20'h99999, 8'h99));
        lock_wr = 1'b0;
        check32("R11 write beats load", lock_rdata, lk_word(0, 5));
        check32("R11 dropped load no error", {31'b0, load_err}, 32'h0);
        look(32'h00B0_0000, 1'b0, 32'h0, 8'h0, "R11 dropped load wrote nothing");

        repeat (2) @(negedge clk);
        check32("R7 all lookups answered", 32'(expq.size()), 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule